// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block holds the operating state of a serial peripheral core and gates its transfer engine. Software moves the core between three states (reset, run and pause) by writing a two-bit code into a state register over a simple write/read register port. Every accepted change is followed by a fixed settling window. During that window a read-only valid flag is low, and software waits for the flag to return high before it asks for another change.

The transfer engine is seen only through two outputs. The enable output is high while the core is settled in run. The flush output gives a single-cycle pulse that empties the transmit and receive buffers whenever the core enters reset. Leaving pause for reset is deliberately awkward: it takes two consecutive writes of a dedicated clear code. A separate soft-reset register drops the core straight into reset. A read-only register returns a fixed version word.

The state register also keeps a configuration field above the valid flag. Software updates the state by read-modify-write, so this field must survive state writes.

Top module: `runStateCore`

## Requirements
- R1: After the reset input is released, the state register at address 0x00 reads 0x00000004 (state code 0 = reset, valid bit 2 set, configuration field zero), and both engineEnable and engineFlush are low.
- R2: The state field is bits [1:0]: 0 = reset, 1 = run, 3 = pause. A state-register write made while valid is high, with code 0, 1 or 3, is accepted, and the core moves to that state. The one exception is code 0 from pause (see R6).
- R3: After an accepted state write, bit 2 (valid) reads 0 for exactly 4 cycles. During those cycles bits [1:0] still show the old state. In the cycle that valid returns to 1, bits [1:0] show the new state.
- R4: A write to the state register while valid is 0 is ignored completely: neither the state nor the configuration field changes.
- R5: In pause, two consecutive state-register writes of code 2 move the core to reset, with the normal settling window. A single code-2 write leaves the core in pause with valid high. Any other state write in between, or a soft reset, cancels the first code-2 write.
- R6: A code-2 write outside pause is ignored and leaves valid high. A code-0 write while in pause is also ignored and leaves valid high.
- R7: Bits [15:3] of every state-register write made while valid is high are stored as the configuration field and read back in place, whether or not the state code is accepted. Bits [31:16] and the written value of bit 2 are ignored; bits [31:16] read 0.
- R8: engineEnable is high exactly when the core is settled in run (state 1 with valid high). It is low during settling and in reset or pause.
- R9: engineFlush pulses high for exactly one cycle in the cycle the state field becomes reset from run or pause. An accepted reset-to-reset write gives no pulse.
- R10: A write with bit 0 set to the soft-reset register at address 0x04 puts the core into reset with valid high, clears the configuration field and any pending clear code, and pulses engineFlush once, all visible the next cycle. A write with bit 0 clear has no effect.
- R11: Address 0x08 reads the version word 0x20020001, which is not below 0x20010001. Address 0x04 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe for the current address |
| regAddr | input | 8 | Byte address for both write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| engineEnable | output | 1 | Transfer engine may shift |
| engineFlush | output | 1 | One-cycle pulse that empties the engine buffers |

## Verification
Directed sequences walk the state graph along its awkward edges. These include pause with one clear code, pause with two clear codes, a clear code cancelled by a different write, and a clear code cancelled by a soft reset. They also cover the ignored codes and a write issued in the middle of a settling window. Each sequence shows whether the design tracks its arming state correctly or silently accepts a forbidden transition.

A seeded random stream of codes, configuration values and occasional soft resets runs against a bench model of the state graph. Every accepted write is sampled at the last busy cycle and at the first settled cycle. This separates an off-by-one settling length from a wrong target state. It also catches a flush pulse that is missing or that fires on a reset-to-reset write.

// File: rtl/runstate_pkg.sv
package runstate_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,
    ST_PAUSE = 2'd3
  } runCode_t;

  // strobes from control to the register datapath
  typedef struct packed {
    logic cfgLoad;
    logic cfgClear;
  } cfgStrobe_t;

endpackage

// File: rtl/runStateCtrl.sv
module runStateCtrl
  import runstate_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          SETTLE     = 4,
  parameter logic [7:0]  STATE_ADDR = 8'h00,
  parameter logic [7:0]  SRST_ADDR  = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrCode,
  output runCode_t          curState,
  output logic              stateValid,
  output logic              engineEnable,
  output logic              engineFlush,
  output cfgStrobe_t        strobe
);

  localparam int CNT_W = $clog2(SETTLE + 1);

  runCode_t         pendState;
  logic [CNT_W-1:0] settleCnt;
  logic             clearArmed;
  logic             armNext;
  logic             acceptWr;
  runCode_t         target;
  logic             flushQ;
  logic             stateWr;
  logic             srstWr;
  runCode_t         code;

  assign stateValid = (settleCnt == CNT_W'(0));
  assign stateWr    = wrEn && (wrAddr == ADDR_W'(STATE_ADDR)) && stateValid;
  assign srstWr     = wrEn && (wrAddr == ADDR_W'(SRST_ADDR)) && wrCode[0];
  assign code       = runCode_t'(wrCode);

  always_comb begin
    acceptWr = 1'b0;
    target   = curState;
    armNext  = clearArmed;
    if (stateWr) begin
      armNext = 1'b0;
      case (code)
        ST_RESET: begin
          if (curState != ST_PAUSE) begin
            acceptWr = 1'b1;
            target   = ST_RESET;
          end
        end
        ST_RUN, ST_PAUSE: begin
          acceptWr = 1'b1;
          target   = code;
        end
        default: begin
          if (curState == ST_PAUSE) begin
            if (clearArmed) begin
              acceptWr = 1'b1;
              target   = ST_RESET;
            end else begin
              armNext = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= ST_RESET;
      pendState  <= ST_RESET;
      settleCnt  <= '0;
      clearArmed <= 1'b0;
      flushQ     <= 1'b0;
    end else if (srstWr) begin
      curState   <= ST_RESET;
      pendState  <= ST_RESET;
      settleCnt  <= '0;
      clearArmed <= 1'b0;
      flushQ     <= 1'b1;
    end else begin
      flushQ     <= 1'b0;
      clearArmed <= armNext;
      if (acceptWr) begin
        pendState <= target;
        settleCnt <= CNT_W'(SETTLE);
      end else if (settleCnt != CNT_W'(0)) begin
        settleCnt <= settleCnt - CNT_W'(1);
        if (settleCnt == CNT_W'(1)) begin
          curState <= pendState;
          flushQ   <= (pendState == ST_RESET) && (curState != ST_RESET);
        end
      end
    end
  end

  assign engineEnable    = (curState == ST_RUN) && stateValid;
  assign engineFlush     = flushQ;
  assign strobe.cfgLoad  = stateWr;
  assign strobe.cfgClear = srstWr;

endmodule

// File: rtl/runStateRegs.sv
module runStateRegs
  import runstate_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          CFG_W      = 13,
  parameter logic [7:0]  STATE_ADDR = 8'h00,
  parameter logic [7:0]  VER_ADDR   = 8'h08,
  parameter logic [31:0] VERSION    = 32'h2002_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [CFG_W-1:0]  cfgIn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  runCode_t          curState,
  input  logic              stateValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int CFG_LSB = 3;
  localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

  logic [CFG_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cfgQ <= '0;
    else if (strobe.cfgClear) cfgQ <= '0;
    else if (strobe.cfgLoad)  cfgQ <= cfgIn;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(STATE_ADDR)) begin
      rdData[CFG_MSB:CFG_LSB] = cfgQ;
      rdData[2]               = stateValid;
      rdData[1:0]             = curState;
    end else if (rdAddr == ADDR_W'(VER_ADDR)) begin
      rdData = DATA_W'(VERSION);
    end
  end

endmodule

// File: rtl/runStateCore.sv
module runStateCore
  import runstate_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          CFG_W      = 13,
  parameter int          SETTLE     = 4,
  parameter logic [7:0]  STATE_ADDR = 8'h00,
  parameter logic [7:0]  SRST_ADDR  = 8'h04,
  parameter logic [7:0]  VER_ADDR   = 8'h08,
  parameter logic [31:0] VERSION    = 32'h2002_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              engineEnable,
  output logic              engineFlush
);

  runCode_t   curState;
  logic       stateValid;
  cfgStrobe_t strobe;
  logic       unusedBits;

  assign unusedBits = &{1'b0, regWrData[DATA_W-1:CFG_W+3], regWrData[2]};

  runStateCtrl #(
    .ADDR_W(ADDR_W), .SETTLE(SETTLE),
    .STATE_ADDR(STATE_ADDR), .SRST_ADDR(SRST_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .wrAddr(regAddr), .wrCode(regWrData[1:0]),
    .curState(curState), .stateValid(stateValid),
    .engineEnable(engineEnable), .engineFlush(engineFlush),
    .strobe(strobe)
  );

  runStateRegs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W),
    .STATE_ADDR(STATE_ADDR), .VER_ADDR(VER_ADDR), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgIn(regWrData[CFG_W+2:3]), .rdAddr(regAddr),
    .curState(curState), .stateValid(stateValid),
    .rdData(regRdData)
  );

endmodule

// File: rtl/runStateCore_chk.sv
module runStateCore_chk
  import runstate_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 32,
  parameter int         SETTLE     = 4,
  parameter logic [7:0] STATE_ADDR = 8'h00,
  parameter logic [7:0] SRST_ADDR  = 8'h04
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input runCode_t          curState,
  input logic              stateValid,
  input logic              engineEnable,
  input logic              engineFlush
);

  logic [31:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lowCnt <= '0;
    else if (stateValid) lowCnt <= '0;
    else                 lowCnt <= lowCnt + 32'd1;
  end

  // R8: enable only while settled in run
  assert_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    engineEnable |-> (curState == ST_RUN && stateValid));

  // R3: reported state frozen while settling
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stateValid |-> $stable(curState));

  // R3: busy window never longer than the settle time
  assert_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stateValid |-> (lowCnt < 32'(SETTLE)));

  // R9: flush is a single-cycle pulse, only in reset
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    engineFlush |=> !engineFlush);
  assert_flushstate_R9: assert property (@(posedge clk) disable iff (!rstN)
    engineFlush |-> (curState == ST_RESET));

  // R6: clear code outside pause changes nothing
  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(STATE_ADDR) && stateValid &&
     regWrData[1:0] == 2'd2 && curState != ST_PAUSE)
    |=> (stateValid && $stable(curState)));

  // R10: soft reset lands in settled reset with a flush
  assert_srst_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(SRST_ADDR) && regWrData[0])
    |=> (curState == ST_RESET && stateValid && engineFlush));

endmodule

bind runStateCore runStateCore_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE),
  .STATE_ADDR(STATE_ADDR), .SRST_ADDR(SRST_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .curState(curState), .stateValid(stateValid),
  .engineEnable(engineEnable), .engineFlush(engineFlush)
);

// File: tb/tb_runStateCore.sv
module tb_runStateCore;

  localparam logic [7:0] A_STATE = 8'h00;
  localparam logic [7:0] A_SRST  = 8'h04;
  localparam logic [7:0] A_VER   = 8'h08;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engineEnable;
  logic        engineFlush;

  int checks = 0;
  int errors = 0;

  logic [1:0]  expState = 2'd0;
  logic [12:0] expCfg = '0;
  logic        armed = 1'b0;

  always #4 clk = ~clk;

  runStateCore dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .engineEnable(engineEnable), .engineFlush(engineFlush)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] stateWord(logic [12:0] cfg, logic v, logic [1:0] st);
    return {16'h0, cfg, v, st};
  endfunction

  // returns {accept, target}
  function automatic logic [2:0] predict(logic [1:0] cur, logic [1:0] code, logic arm);
    case (code)
      2'd0:    return (cur == 2'd3) ? {1'b0, cur} : {1'b1, 2'd0};
      2'd1:    return {1'b1, 2'd1};
      2'd3:    return {1'b1, 2'd3};
      default: return (cur == 2'd3 && arm) ? {1'b1, 2'd0} : {1'b0, cur};
    endcase
  endfunction

  task automatic doWrite(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [7:0] addr, output logic [31:0] data);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  // state write issued while the model says valid is high
  task automatic stateWrite(logic [1:0] code, logic [12:0] cfg);
    logic [2:0]  p;
    logic [1:0]  old;
    logic [31:0] rd;
    p   = predict(expState, code, armed);
    old = expState;
    armed  = (code == 2'd2 && expState == 2'd3 && !armed);
    expCfg = cfg;
    doWrite(A_STATE, {16'($urandom), cfg, 1'($urandom), code});
    readReg(A_STATE, rd);
    if (p[2]) begin
      check("R3 busy after accept", rd, stateWord(cfg, 1'b0, old));
      check("R8 enable off while settling", 32'(engineEnable), 32'd0);
      repeat (3) @(negedge clk);
      readReg(A_STATE, rd);
      check("R3 still busy at cycle 4", rd, stateWord(cfg, 1'b0, old));
      @(negedge clk);
      readReg(A_STATE, rd);
      check("R2 settled new state", rd, stateWord(cfg, 1'b1, p[1:0]));
      check("R9 flush on entering reset", 32'(engineFlush),
            32'(p[1:0] == 2'd0 && old != 2'd0));
      check("R8 enable when settled", 32'(engineEnable), 32'(p[1:0] == 2'd1));
      @(negedge clk);
      check("R9 flush one cycle", 32'(engineFlush), 32'd0);
      expState = p[1:0];
    end else begin
      check("R6 R5 ignored code keeps state", rd, stateWord(cfg, 1'b1, old));
      check("R8 enable unchanged", 32'(engineEnable), 32'(old == 2'd1));
      check("R9 no flush on ignore", 32'(engineFlush), 32'd0);
    end
  endtask

  task automatic softReset();
    logic [31:0] rd;
    doWrite(A_SRST, {31'($urandom), 1'b1});
    readReg(A_STATE, rd);
    check("R10 soft reset state", rd, 32'h4);
    check("R10 soft reset flush", 32'(engineFlush), 32'd1);
    check("R10 soft reset enable", 32'(engineEnable), 32'd0);
    @(negedge clk);
    check("R10 flush single", 32'(engineFlush), 32'd0);
    expState = 2'd0; expCfg = '0; armed = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 read-only words
    readReg(A_STATE, rd); check("R1 state after reset", rd, 32'h4);
    check("R1 enable low", 32'(engineEnable), 32'd0);
    check("R1 flush low", 32'(engineFlush), 32'd0);
    readReg(A_VER, rd); check("R11 version", rd, 32'h2002_0001);
    check("R11 version not below minimum", 32'(rd >= 32'h2001_0001), 32'd1);
    readReg(A_SRST, rd); check("R11 soft reset reads zero", rd, 32'h0);

    // R2 R7 basic walk; R6 ignored codes; R5 double clear
    stateWrite(2'd2, 13'h0AA);          // R6 clear outside pause
    stateWrite(2'd0, 13'h155);          // R9 reset to reset, no flush
    stateWrite(2'd1, 13'h1F0);
    stateWrite(2'd3, 13'h00F);
    stateWrite(2'd0, 13'h0F0);          // R6 code 0 from pause
    stateWrite(2'd2, 13'h111);          // R5 single clear
    stateWrite(2'd2, 13'h222);          // R5 second clear -> reset

    // R5 clear cancelled by another write
    stateWrite(2'd3, 13'h001);
    stateWrite(2'd2, 13'h002);
    stateWrite(2'd3, 13'h003);
    stateWrite(2'd2, 13'h004);
    check("R5 cancelled clear stays pause", 32'(expState), 32'd3);
    stateWrite(2'd1, 13'h005);          // arm cancelled, run

    // R4 write during settling is ignored
    stateWrite(2'd3, 13'h100);
    doWrite(A_STATE, {16'h0, 13'h0AB, 1'b0, 2'd1});
    doWrite(A_STATE, {16'h0, 13'h0CD, 1'b0, 2'd0});
    repeat (2) @(negedge clk);
    readReg(A_STATE, rd);
    check("R4 busy write kept old settle", rd, stateWord(13'h0AB, 1'b1, 2'd1));
    expState = 2'd1; expCfg = 13'h0AB;

    // R10 soft reset with bit 0 clear has no effect
    doWrite(A_SRST, 32'hFFFF_FFFE);
    readReg(A_STATE, rd);
    check("R10 bit0 clear ignored", rd, stateWord(13'h0AB, 1'b1, 2'd1));
    softReset();

    // R10 soft reset clears pending clear code
    stateWrite(2'd3, 13'h077);
    stateWrite(2'd2, 13'h078);
    softReset();
    stateWrite(2'd3, 13'h079);
    stateWrite(2'd2, 13'h07A);
    check("R10 arm cleared by soft reset", 32'(expState), 32'd3);

    // random stream against the model
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) == 0) softReset();
      else stateWrite(2'($urandom), 13'($urandom));
    end

    readReg(A_VER, rd); check("R11 version at end", rd, 32'h2002_0001);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule